// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block converts an asynchronous serial input line into parallel characters, each delivered with three status bits: parity error, framing error and break. It normally runs from a single-cycle oversampling tick in the system clock domain (sixteen ticks per bit by default). In that mode it confirms each start bit at mid-bit and then samples every following bit at its centre. A second mode takes an externally supplied bit clock and samples the line once on each rising edge of that clock. In this mode the start bit is not confirmed.

Completed characters go out on a push strobe towards a downstream FIFO. If that FIFO reports full, the character waits inside the receiver. If a new character starts while one is still waiting, the waiting character is dropped and an overrun pulse is raised. A line held low for a whole character produces exactly one all-zero break character. A change-of-break pulse marks both the start and the end of the break, and the end is accepted only after the line has been high for two clock edges in a row. After a framing error on a character that was not all zero, a line that is still low half a bit later is taken as the next start bit.

Top module: `uart_rx_os`

## Requirements
- R1: In oversampling mode, a falling edge of the synchronised line restarts the tick counter, and the line is sampled again when the counter reaches OVS/2-1. If it is low, a character begins. If it is high, nothing is pushed and the receiver hunts for a new falling edge.
- R2: After a confirmed start, one bit is sampled every OVS ticks, least significant bit first. With eight data bits and no parity, the pushed byte equals the byte sent, and a good stop bit gives all three status bits 0.
- R3: char_len selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the selected length are pushed as 0.
- R4: par_mode selects the parity: 0 is none, 1 is even, 2 is odd, and 3 behaves as none. When parity is on, one parity bit follows the data. push_perr is 1 when that bit does not match the chosen parity, and it is always 0 when parity is off.
- R5: A low stop-bit sample on a character that was not entirely low pushes the character with push_ferr=1. In oversampling mode, if the line is still low OVS/2 ticks after that stop sample, the receiver treats that moment as a new start edge.
- R6: If every sample of a character, the stop bit included, is low, exactly one character is pushed, with data 0, push_brk=1, push_perr=0 and push_ferr=0. brk_change pulses once at that point, and nothing more is pushed while the line stays low.
- R7: A break ends only when the synchronised line is high on two successive clock edges. brk_change then pulses a second time and start hunting resumes. A line that is high for a single clock cycle does not end the break.
- R8: With mode_1x=1, the line is sampled on each rising edge of rxc1x. A low sample while idle starts a character without any confirmation, and the following samples carry data, parity and stop.
- R9: A character that completes while fifo_full=1 is held and is not pushed. It is pushed once fifo_full falls. If a new start is confirmed while the held character is still blocked, the held character is discarded and overrun pulses for one cycle.
- R10: While enable=0 the receiver ignores the line and returns to idle hunting. Line activity then causes no push and no brk_change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Receiver enable |
| mode_1x | input | 1 | 1: sample on rxc1x rising edges; 0: oversampling tick mode |
| tick16 | input | 1 | Single-cycle oversampling tick, OVS per bit |
| rxc1x | input | 1 | External bit clock used in 1X mode |
| rxd | input | 1 | Asynchronous serial input, idle high |
| char_len | input | 2 | Data bits: 0..3 selects 5..8 |
| par_mode | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| fifo_full | input | 1 | Downstream FIFO cannot accept a push |
| push | output | 1 | One-cycle strobe writing a character |
| push_data | output | 8 | Received character, unused upper bits zero |
| push_perr | output | 1 | Parity error of the pushed character |
| push_ferr | output | 1 | Framing error of the pushed character |
| push_brk | output | 1 | Pushed character is a break |
| brk_change | output | 1 | One-cycle pulse at break start and at break end |
| overrun | output | 1 | One-cycle pulse when a held character is discarded |

## Verification
A wrong bit counter or tick phase appears at the ports within one character time, as a shifted or wrong byte on the next push or as a push that comes too early or too late. A stuck break-wait state shows up as a missing second brk_change pulse, and as later characters that are never pushed. A hold register that forgets or keeps its character wrongly shows up as a lost or duplicated push once fifo_full falls, or as a wrong overrun count after the next start bit.

// File: rtl/uart_rx_os_pkg.sv
package uart_rx_os_pkg;
   localparam int DATA_W = 8;

   typedef enum logic [1:0] {
      PAR_NONE = 2'd0,
      PAR_EVEN = 2'd1,
      PAR_ODD  = 2'd2,
      PAR_RSV  = 2'd3
   } par_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_SHIFT,
      ST_REARM,
      ST_BRKW
   } rx_state_e;

   typedef struct packed {
      logic [DATA_W-1:0] data;
      logic              perr;
      logic              ferr;
      logic              brk;
   } rx_char_t;
endpackage

// File: rtl/uart_rx_os_sync.sv
module uart_rx_os_sync #(
   parameter int STAGES = 2,
   parameter bit INIT   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] ff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= {STAGES{INIT}};
      else        ff <= {ff[STAGES-2:0], d};
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/uart_rx_os_frame.sv
module uart_rx_os_frame
   import uart_rx_os_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic       mode_1x,
   input  logic       tick16,
   input  logic       rxd_s,
   input  logic       rxc_s,
   input  logic [1:0] char_len,
   input  logic [1:0] par_mode,
   output logic       char_vld,
   output rx_char_t   char_o,
   output logic       start_ok,
   output logic       brk_chg
);
   localparam int CW = $clog2(OVS);
   localparam int BW = $clog2(DATA_W + 2);
   localparam int IW = $clog2(DATA_W);
   localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OVS - 1);

   rx_state_e         st;
   logic [CW-1:0]     cnt;
   logic [BW-1:0]     bitn;
   logic [DATA_W-1:0] data;
   logic              pbit, all_low, hi1;
   logic              rxd_d, rxc_d;

   logic              rxd_fall, rxc_rise, strobe, par_on, perr_c;
   logic [BW-1:0]     dlen, nbits;
   par_e              pm;

   assign pm       = par_e'(par_mode);
   assign par_on   = (pm == PAR_EVEN) || (pm == PAR_ODD);
   assign dlen     = BW'(char_len) + BW'(5);
   assign nbits    = dlen + BW'(par_on);
   assign rxd_fall = rxd_d & ~rxd_s;
   assign rxc_rise = rxc_s & ~rxc_d;
   assign strobe   = mode_1x ? rxc_rise : (tick16 && cnt == MID);

   always_comb begin
      case (pm)
         PAR_EVEN: perr_c = (^data) ^ pbit;
         PAR_ODD:  perr_c = ~((^data) ^ pbit);
         default:  perr_c = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         bitn     <= '0;
         data     <= '0;
         pbit     <= 1'b0;
         all_low  <= 1'b0;
         hi1      <= 1'b0;
         rxd_d    <= 1'b1;
         rxc_d    <= 1'b0;
         char_vld <= 1'b0;
         char_o   <= '0;
         start_ok <= 1'b0;
         brk_chg  <= 1'b0;
      end else begin
         rxd_d    <= rxd_s;
         rxc_d    <= rxc_s;
         char_vld <= 1'b0;
         start_ok <= 1'b0;
         brk_chg  <= 1'b0;
         if (tick16) cnt <= cnt + 1'b1;
         if (!enable) begin
            st <= ST_IDLE;
         end else begin
            case (st)
               ST_IDLE: begin
                  if (mode_1x) begin
                     if (rxc_rise && !rxd_s) begin
                        st <= ST_SHIFT; start_ok <= 1'b1;
                        bitn <= '0; data <= '0; pbit <= 1'b0; all_low <= 1'b1;
                     end
                  end else if (rxd_fall) begin
                     st  <= ST_START;
                     cnt <= '0;
                  end
               end
               ST_START: begin
                  if (mode_1x) st <= ST_IDLE;
                  else if (tick16 && cnt == MID) begin
                     if (!rxd_s) begin
                        st <= ST_SHIFT; start_ok <= 1'b1;
                        bitn <= '0; data <= '0; pbit <= 1'b0; all_low <= 1'b1;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               ST_SHIFT: begin
                  if (strobe) begin
                     if (bitn < nbits) begin
                        if (bitn < dlen) data[bitn[IW-1:0]] <= rxd_s;
                        else             pbit <= rxd_s;
                        all_low <= all_low & ~rxd_s;
                        bitn    <= bitn + 1'b1;
                     end else begin
                        char_vld <= 1'b1;
                        if (all_low && !rxd_s) begin
                           char_o.data <= '0;
                           char_o.perr <= 1'b0;
                           char_o.ferr <= 1'b0;
                           char_o.brk  <= 1'b1;
                           brk_chg     <= 1'b1;
                           hi1         <= 1'b0;
                           st          <= ST_BRKW;
                        end else begin
                           char_o.data <= data;
                           char_o.perr <= perr_c;
                           char_o.ferr <= ~rxd_s;
                           char_o.brk  <= 1'b0;
                           st <= (!rxd_s && !mode_1x) ? ST_REARM : ST_IDLE;
                        end
                     end
                  end
               end
               ST_REARM: begin
                  if (mode_1x) st <= ST_IDLE;
                  else if (tick16 && cnt == LAST) begin
                     if (!rxd_s) begin
                        st  <= ST_START;
                        cnt <= '0;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               ST_BRKW: begin
                  if (rxd_s) begin
                     if (hi1) begin
                        brk_chg <= 1'b1;
                        st      <= ST_IDLE;
                     end
                     hi1 <= 1'b1;
                  end else begin
                     hi1 <= 1'b0;
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_rx_os_hold.sv
module uart_rx_os_hold
   import uart_rx_os_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     char_vld,
   input  rx_char_t char_i,
   input  logic     start_ok,
   input  logic     fifo_full,
   output logic     push,
   output rx_char_t push_char,
   output logic     overrun
);
   logic     held_v;
   rx_char_t held_c;

   assign push      = !fifo_full && (held_v || char_vld);
   assign push_char = held_v ? held_c : char_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_v  <= 1'b0;
         held_c  <= '0;
         overrun <= 1'b0;
      end else begin
         overrun <= 1'b0;
         if (held_v) begin
            if (!fifo_full) begin
               held_v <= 1'b0;
            end else if (start_ok) begin
               held_v  <= 1'b0;
               overrun <= 1'b1;
            end
         end else if (char_vld && fifo_full) begin
            held_v <= 1'b1;
            held_c <= char_i;
         end
      end
   end
endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os
   import uart_rx_os_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              mode_1x,
   input  logic              tick16,
   input  logic              rxc1x,
   input  logic              rxd,
   input  logic [1:0]        char_len,
   input  logic [1:0]        par_mode,
   input  logic              fifo_full,
   output logic              push,
   output logic [DATA_W-1:0] push_data,
   output logic              push_perr,
   output logic              push_ferr,
   output logic              push_brk,
   output logic              brk_change,
   output logic              overrun
);
   if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("OVS must be a power of two of at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic     rxd_s, rxc_s, char_vld, start_ok;
   rx_char_t char_w, push_char;

   uart_rx_os_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_rxd (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s));

   uart_rx_os_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_rxc (
      .clk(clk), .rst_n(rst_n), .d(rxc1x), .q(rxc_s));

   uart_rx_os_frame #(.OVS(OVS)) u_frame (
      .clk(clk), .rst_n(rst_n), .enable(enable), .mode_1x(mode_1x),
      .tick16(tick16), .rxd_s(rxd_s), .rxc_s(rxc_s),
      .char_len(char_len), .par_mode(par_mode),
      .char_vld(char_vld), .char_o(char_w), .start_ok(start_ok),
      .brk_chg(brk_change));

   uart_rx_os_hold u_hold (
      .clk(clk), .rst_n(rst_n), .char_vld(char_vld), .char_i(char_w),
      .start_ok(start_ok), .fifo_full(fifo_full),
      .push(push), .push_char(push_char), .overrun(overrun));

   assign push_data = push_char.data;
   assign push_perr = push_char.perr;
   assign push_ferr = push_char.ferr;
   assign push_brk  = push_char.brk;
endmodule

// File: rtl/uart_rx_os_chk.sv
module uart_rx_os_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       enable,
   input logic [1:0] char_len,
   input logic [1:0] par_mode,
   input logic       push,
   input logic [7:0] push_data,
   input logic       push_perr,
   input logic       push_ferr,
   input logic       push_brk,
   input logic       brk_change,
   input logic       overrun
);
   assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> ((push_data >> ({2'b00, char_len} + 4'd5)) == 8'd0));

   assert_no_par_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (push && (par_mode == 2'd0 || par_mode == 2'd3)) |-> !push_perr);

   assert_break_char_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && push_brk) |-> (push_data == 8'd0 && !push_perr && !push_ferr));

   assert_overrun_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> !push);

   assert_quiet_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(enable) |-> !brk_change);
endmodule

bind uart_rx_os uart_rx_os_chk u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .char_len(char_len),
   .par_mode(par_mode), .push(push), .push_data(push_data),
   .push_perr(push_perr), .push_ferr(push_ferr), .push_brk(push_brk),
   .brk_change(brk_change), .overrun(overrun));

// File: tb/tb_uart_rx_os.sv
module tb_uart_rx_os;
   localparam int BIT = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       mode_1x = 1'b0;
   logic       tick16 = 1'b0;
   logic       rxc1x = 1'b0;
   logic       rxd = 1'b1;
   logic [1:0] char_len = 2'd3;
   logic [1:0] par_mode = 2'd0;
   logic       fifo_full = 1'b0;
   logic       push;
   logic [7:0] push_data;
   logic       push_perr, push_ferr, push_brk, brk_change, overrun;

   int checks = 0;
   int errors = 0;
   int push_cnt = 0;
   int brk_cnt = 0;
   int ovr_cnt = 0;
   bit done = 1'b0;

   logic [10:0] exp_q[$];
   string       req_q[$];

   uart_rx_os dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .mode_1x(mode_1x),
      .tick16(tick16), .rxc1x(rxc1x), .rxd(rxd), .char_len(char_len),
      .par_mode(par_mode), .fifo_full(fifo_full), .push(push),
      .push_data(push_data), .push_perr(push_perr), .push_ferr(push_ferr),
      .push_brk(push_brk), .brk_change(brk_change), .overrun(overrun));

   always #5 clk = ~clk;

   initial begin
      int tc = 0;
      forever begin
         @(negedge clk);
         tc = (tc + 1) % 4;
         tick16 = (tc == 0);
      end
   end

   initial begin
      forever begin
         repeat (8) @(negedge clk);
         rxc1x = ~rxc1x;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (brk_change) brk_cnt++;
         if (overrun) ovr_cnt++;
         if (push) begin
            push_cnt++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R2", "unexpected push", int'(push_data), -1);
            end else begin
               logic [10:0] e;
               string r;
               e = exp_q.pop_front();
               r = req_q.pop_front();
               check({push_data, push_perr, push_ferr, push_brk} == e, r,
                     "pushed char {data,perr,ferr,brk}",
                     int'({push_data, push_perr, push_ferr, push_brk}), int'(e));
            end
         end
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_char(input logic [7:0] d, input bit pe, input bit fe,
                              input bit bk, input string r);
      exp_q.push_back({d, pe, fe, bk});
      req_q.push_back(r);
   endtask

   function automatic logic par_bit(input logic [7:0] m, input int par, input bit bad);
      logic p;
      p = ^m;
      if (par == 2) p = ~p;
      if (bad) p = ~p;
      return p;
   endfunction

   task automatic send(input logic [7:0] d, input int len, input int par,
                       input bit bad, input bit stopb, input bit exp,
                       input string r);
      logic [7:0] m;
      m = d & 8'((9'd1 << len) - 9'd1);
      if (exp) expect_char(m, bad && par != 0, !stopb, 1'b0, r);
      @(negedge clk);
      rxd = 1'b0; wait_clk(BIT);
      for (int i = 0; i < len; i++) begin
         rxd = m[i]; wait_clk(BIT);
      end
      if (par != 0) begin
         rxd = par_bit(m, par, bad); wait_clk(BIT);
      end
      rxd = stopb; wait_clk(BIT);
      if (stopb) wait_clk(BIT);
   endtask

   task automatic send1x(input logic [7:0] d, input int len, input int par,
                         input string r);
      logic [7:0] m;
      m = d & 8'((9'd1 << len) - 9'd1);
      expect_char(m, 1'b0, 1'b0, 1'b0, r);
      @(negedge rxc1x); rxd = 1'b0;
      for (int i = 0; i < len; i++) begin
         @(negedge rxc1x); rxd = m[i];
      end
      if (par != 0) begin
         @(negedge rxc1x); rxd = par_bit(m, par, 1'b0);
      end
      @(negedge rxc1x); rxd = 1'b1;
      @(negedge rxc1x);
      @(negedge rxc1x);
   endtask

   initial begin
      int pc;
      wait_clk(5);
      check(push == 1'b0 && overrun == 1'b0 && brk_change == 1'b0, "R10",
            "outputs during reset", int'({push, overrun, brk_change}), 0);
      rst_n = 1'b1;
      wait_clk(3);
      check(push == 1'b0 && overrun == 1'b0 && brk_change == 1'b0, "R10",
            "outputs after reset", int'({push, overrun, brk_change}), 0);
      enable = 1'b1;
      wait_clk(BIT);

      // R2: eight data bits, no parity
      send(8'hA5, 8, 0, 0, 1, 1, "R2");
      send(8'h3C, 8, 0, 0, 1, 1, "R2");

      // R1: a short low glitch fails start validation
      pc = push_cnt;
      @(negedge clk); rxd = 1'b0; wait_clk(12); rxd = 1'b1;
      wait_clk(4 * BIT);
      check(push_cnt == pc, "R1", "pushes after rejected start", push_cnt - pc, 0);
      send(8'h81, 8, 0, 0, 1, 1, "R1");

      // R4: parity even/odd, good and bad
      char_len = 2'd2; par_mode = 2'd1;
      send(8'h55, 7, 1, 0, 1, 1, "R4");
      send(8'h23, 7, 1, 1, 1, 1, "R4");
      par_mode = 2'd2;
      send(8'h6E, 7, 2, 0, 1, 1, "R4");
      send(8'h6E, 7, 2, 1, 1, 1, "R4");

      // R3: short characters, upper bits zero
      char_len = 2'd0;
      send(8'hFF, 5, 2, 0, 1, 1, "R3");
      char_len = 2'd1; par_mode = 2'd0;
      send(8'hEA, 6, 0, 0, 1, 1, "R3");
      char_len = 2'd3;

      // R5: framing error, low line re-arms as the next start bit
      send(8'h5A, 8, 0, 0, 0, 1, "R5");
      send(8'h01, 8, 0, 0, 1, 1, "R5");

      // R6 / R7: break
      expect_char(8'h00, 1'b0, 1'b0, 1'b1, "R6");
      pc = brk_cnt;
      @(negedge clk); rxd = 1'b0;
      wait_clk(25 * BIT);
      check(brk_cnt - pc == 1, "R6", "brk_change pulses during break", brk_cnt - pc, 1);
      check(exp_q.size() == 0, "R6", "break chars outstanding", exp_q.size(), 0);
      rxd = 1'b1; @(negedge clk); rxd = 1'b0;
      wait_clk(20);
      check(brk_cnt - pc == 1, "R7", "brk_change after 1-cycle high", brk_cnt - pc, 1);
      rxd = 1'b1;
      wait_clk(20);
      check(brk_cnt - pc == 2, "R7", "brk_change after break end", brk_cnt - pc, 2);
      wait_clk(BIT);
      send(8'h33, 8, 0, 0, 1, 1, "R7");

      // R8: 1X mode with external bit clock
      mode_1x = 1'b1; par_mode = 2'd1;
      wait_clk(40);
      send1x(8'h96, 8, 1, "R8");
      char_len = 2'd0; par_mode = 2'd0;
      send1x(8'h1B, 5, 0, "R8");
      char_len = 2'd3;
      mode_1x = 1'b0;
      wait_clk(BIT);

      // R9: full FIFO holds, overrun discards
      fifo_full = 1'b1;
      pc = push_cnt;
      send(8'h11, 8, 0, 0, 1, 1, "R9");
      check(push_cnt == pc, "R9", "pushes while full", push_cnt - pc, 0);
      fifo_full = 1'b0;
      wait_clk(5);
      check(push_cnt == pc + 1, "R9", "push after release", push_cnt - pc, 1);
      fifo_full = 1'b1;
      pc = ovr_cnt;
      send(8'h99, 8, 0, 0, 1, 0, "R9");
      check(ovr_cnt == pc, "R9", "overrun before new start", ovr_cnt - pc, 0);
      send(8'h22, 8, 0, 0, 1, 1, "R9");
      check(ovr_cnt == pc + 1, "R9", "overrun pulses", ovr_cnt - pc, 1);
      fifo_full = 1'b0;
      wait_clk(5);

      // R10: disabled receiver ignores the line
      enable = 1'b0;
      pc = push_cnt;
      send(8'h77, 8, 0, 0, 1, 0, "R10");
      @(negedge clk); rxd = 1'b0; wait_clk(12 * BIT); rxd = 1'b1;
      wait_clk(BIT);
      check(push_cnt == pc, "R10", "pushes while disabled", push_cnt - pc, 0);
      enable = 1'b1;
      wait_clk(BIT);
      send(8'h42, 8, 0, 0, 1, 1, "R10");

      wait_clk(20);
      check(exp_q.size() == 0, "R2", "expected chars never pushed", exp_q.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R2 watchdog expired: actual 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule